// File: doc/BRIEF.md
# Four-Phase Handshake Bus Read/Write Engine

This block carries single-word transfers across a simple synchronous processor-style bus. It holds two actors. The first is a requester on the processor side. It takes a command from its local port, raises a request strobe, and drives the address and a read/write line. The second is a responder on the device side. It owns a small register-file backing store and answers with an acknowledge. For reads it also raises a data-valid flag and places the stored word on the return data lines.

Each transfer runs through four steps in a fixed order:

1. The request rises.
2. The acknowledge rises.
3. The responder drops the acknowledge once it has finished.
4. The requester withdraws the request only after it has seen the acknowledge low.

The responder can be slowed by a parameterised number of wait cycles before it acknowledges. This models a slow device. Writes use the same four steps and store the word into the backing store.

A user issues a command when `cmd_ready` is high. The result comes back as a one-cycle `rsp_valid` pulse, which carries the read data for reads. The bus lines are brought out so that the protocol can be observed.

Top module: `hs_bus_read`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_req`, `bus_ack`, `bus_drdy` and `rsp_valid` are low and `cmd_ready` is high.
- R2: A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. From the next cycle, `bus_req` is high and `cmd_ready` is low. `bus_ack` is never high while `bus_req` is low.
- R3: `bus_ack` rises only in answer to a request that was already high in the previous cycle.
- R4: `bus_req` falls only in a cycle that follows a cycle with `bus_ack` low. The acknowledge is always released before the request.
- R5: `bus_addr` and `bus_rw` keep their values for as long as `bus_req` stays high.
- R6: `bus_rw` is 1 for a read and 0 for a write. `cmd_write`=1 selects a write.
- R7: `bus_drdy` is high only while `bus_ack` is high and `bus_rw` is 1. It marks a valid word on the return data lines.
- R8: A read returns the word most recently written to that address. An address never written since reset reads 0.
- R9: `rsp_valid` goes high exactly 5+`WAIT_CYCLES` clock edges after the accepting edge, for reads and writes alike.
- R10: `cmd_valid` has no effect while `cmd_ready` is low. A write offered during a busy transfer does not change the store.
- R11: `rsp_valid` is a single-cycle pulse. During that pulse, `rsp_rdata` holds the word captured while `bus_drdy` and `bus_ack` were both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write word |
| cmd_ready | output | 1 | Requester idle, command can be accepted |
| rsp_valid | output | 1 | Transfer complete pulse |
| rsp_rdata | output | DATA_W | Read word returned |
| bus_req | output | 1 | Request strobe on the bus |
| bus_ack | output | 1 | Acknowledge from the responder |
| bus_rw | output | 1 | Direction line, 1 = read |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_drdy | output | 1 | Return data valid |

## Verification
The bench builds the block with `ADDR_W`=3, `DATA_W`=16 and `WAIT_CYCLES`=2.

The 3-bit address gives an eight-entry store. This makes it cheap to write every entry, read each one back in a shuffled order, and also read entries that were never written.

A nonzero wait count spreads the acknowledge away from the request. This lets the latency check tell a correct wait insertion apart from an off-by-one count. It also leaves a busy window long enough to offer an illegal write in the middle of a transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_ADRS,
        RQ_WAIT,
        RQ_GET,
        RQ_DONE
    } rq_state_e;

    typedef enum logic [2:0] {
        RS_ADRS,
        RS_WAIT,
        RS_ACK,
        RS_SEND,
        RS_RELEASE
    } rs_state_e;

endpackage

// File: rtl/hs_regfile.sv
module hs_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] entry_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [DATA_W-1:0] entry_d;

        always_comb begin
            entry_d = entry_q[i];
            if (we && (waddr == ADDR_W'(i))) begin
                entry_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[i] <= '0;
            end else begin
                entry_q[i] <= entry_d;
            end
        end
    end

    assign rdata = entry_q[raddr];

endmodule

// File: rtl/hs_requester.sv
module hs_requester
    import hs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_rw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_drdy,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        rq_state_e         state;
        logic              req;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } rq_regs_t;

    rq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            RQ_IDLE: begin
                if (cmd_valid) begin
                    r_d.state = RQ_ADRS;
                    r_d.req   = 1'b1;
                    r_d.rw    = ~cmd_write;
                    r_d.addr  = cmd_addr;
                    r_d.wdata = cmd_wdata;
                end
            end
            RQ_ADRS: begin
                r_d.state = RQ_WAIT;
            end
            RQ_WAIT: begin
                // reads capture when ack and data-ready coincide
                if (bus_ack && (bus_drdy || !r_q.rw)) begin
                    if (r_q.rw) begin
                        r_d.rdata = bus_rdata;
                    end
                    r_d.state = RQ_GET;
                end
            end
            RQ_GET: begin
                // request withdrawn only once ack is seen low
                if (!bus_ack) begin
                    r_d.req   = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.state = RQ_DONE;
                end
            end
            RQ_DONE: begin
                r_d.state = RQ_IDLE;
            end
            default: begin
                r_d.state = RQ_IDLE;
                r_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= RQ_IDLE;
            r_q.req   <= 1'b0;
            r_q.rw    <= 1'b1;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == RQ_IDLE);
    assign rsp_valid = r_q.done;
    assign rsp_rdata = r_q.rdata;
    assign bus_req   = r_q.req;
    assign bus_rw    = r_q.rw;
    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata;

endmodule

// File: rtl/hs_responder.sv
module hs_responder
    import hs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_drdy,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 2);

    typedef struct packed {
        rs_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic              ack;
        logic              drdy;
        logic              rw;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } rs_regs_t;

    rs_regs_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        case (s_q.state)
            RS_ADRS: begin
                if (bus_req) begin
                    s_d.addr  = bus_addr;
                    s_d.rw    = bus_rw;
                    s_d.wdata = bus_wdata;
                    s_d.cnt   = CNT_W'(WAIT_CYCLES);
                    s_d.state = RS_WAIT;
                end
            end
            RS_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.ack   = 1'b1;
                    s_d.state = RS_ACK;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            RS_ACK: begin
                s_d.state = RS_SEND;
                if (s_q.rw) begin
                    s_d.drdy  = 1'b1;
                    s_d.rdata = mem_rdata;
                end else begin
                    s_d.we = 1'b1;
                end
            end
            RS_SEND: begin
                s_d.ack   = 1'b0;
                s_d.drdy  = 1'b0;
                s_d.state = RS_RELEASE;
            end
            RS_RELEASE: begin
                if (!bus_req) begin
                    s_d.state = RS_ADRS;
                end
            end
            default: begin
                s_d.state = RS_ADRS;
                s_d.ack   = 1'b0;
                s_d.drdy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.state <= RS_ADRS;
            s_q.cnt   <= '0;
            s_q.ack   <= 1'b0;
            s_q.drdy  <= 1'b0;
            s_q.rw    <= 1'b1;
            s_q.we    <= 1'b0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ack   = s_q.ack;
    assign bus_drdy  = s_q.drdy;
    assign bus_rdata = s_q.rdata;
    assign mem_addr  = s_q.addr;
    assign mem_we    = s_q.we;
    assign mem_wdata = s_q.wdata;

endmodule

// File: rtl/hs_bus_read.sv
module hs_bus_read #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_ack,
    output logic              bus_rw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_drdy
);
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    hs_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_requester (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .bus_req   (bus_req),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_drdy  (bus_drdy),
        .bus_rdata (bus_rdata)
    );

    hs_responder #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_responder (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_rw    (bus_rw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_drdy  (bus_drdy),
        .bus_rdata (bus_rdata),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    hs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/hs_bus_read_chk.sv
module hs_bus_read_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_rw,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_drdy
);
    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> bus_req);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cmd_ready);

    assert_ack_answers_req_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_req));

    assert_ack_released_first_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> !$past(bus_ack));

    assert_addr_rw_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_rw)));

    assert_drdy_read_only_R7: assert property (@(posedge clk) disable iff (rst)
        bus_drdy |-> (bus_ack && bus_rw));

    assert_done_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind hs_bus_read hs_bus_read_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_rw    (bus_rw),
    .bus_addr  (bus_addr),
    .bus_drdy  (bus_drdy)
);

// File: tb/hs_bus_read_tb.sv
module hs_bus_read_tb;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int WC = 2;
    localparam int LAT = 5 + WC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, rsp_valid, bus_req, bus_ack, bus_rw, bus_drdy;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;

    always #2.5 clk = ~clk;

    hs_bus_read #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WC)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_req(bus_req),
        .bus_ack(bus_ack), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_drdy(bus_drdy)
    );

    typedef struct {
        bit      is_read;
        logic [DW-1:0] data;
        int      accept;
        string   tag;
    } item_t;

    item_t         sb_q[$];
    logic [DW-1:0] model [1 << AW];
    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;
    bit            exp_rw = 1'b1;
    bit            finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input string tag);
        item_t it;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_wdata = d;
        exp_rw    = !wr;
        it.is_read = !wr;
        it.data    = wr ? '0 : model[a];
        it.accept  = cyc + 1;
        it.tag     = tag;
        if (wr) model[a] = d;
        sb_q.push_back(it);
        @(negedge clk);
        cmd_valid = 1'b0;
        // R2: request raised on the cycle after acceptance
        check(bus_req && !cmd_ready, "R2", {bus_req, cmd_ready}, 2'b10);
    endtask

    // scoreboard monitor and protocol observer
    logic          p_req = 0, p_ack = 0, p_rsp = 0;
    logic [AW-1:0] p_addr = '0;
    logic          p_rw = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_req && !bus_req) check(!p_ack, "R4", p_ack, 0);
            if (!p_ack && bus_ack) begin
                check(p_req, "R3", p_req, 1);
                check(bus_rw == exp_rw, "R6", bus_rw, exp_rw);
            end
            if (bus_drdy) check(bus_ack && bus_rw, "R7", {bus_ack, bus_rw}, 2'b11);
            if (p_req && bus_req)
                check(bus_addr == p_addr && bus_rw == p_rw, "R5", {bus_rw, bus_addr}, {p_rw, p_addr});
            if (p_rsp) check(!rsp_valid, "R11", rsp_valid, 0);
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R11", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(cyc - it.accept == LAT, "R9", cyc - it.accept, LAT);
                    if (it.is_read) check(rsp_rdata == it.data, it.tag, rsp_rdata, it.data);
                end
            end
        end
        p_req  = bus_req;
        p_ack  = bus_ack;
        p_rsp  = rsp_valid;
        p_addr = bus_addr;
        p_rw   = bus_rw;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!bus_req && !bus_ack && !bus_drdy && !rsp_valid && cmd_ready, "R1",
              {bus_req, bus_ack, bus_drdy, rsp_valid, cmd_ready}, 5'b00001);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !bus_ack && !rsp_valid && cmd_ready, "R1",
              {bus_req, bus_ack, rsp_valid, cmd_ready}, 4'b0001);

        // R8: unwritten entries read zero
        run_op(1'b0, 3'd0, '0, "R8");
        run_op(1'b0, 3'd7, '0, "R8");
        // fill every entry
        for (int i = 0; i < 8; i++) run_op(1'b1, AW'(i), DW'(16'h1100 + i * 16'h0203), "R6");
        // read back in shuffled order
        for (int i = 0; i < 8; i++) run_op(1'b0, AW'((i * 5 + 3) % 8), '0, "R8");
        // overwrite twice, last one wins
        run_op(1'b1, 3'd3, 16'hA5A5, "R8");
        run_op(1'b1, 3'd3, 16'h5A5A, "R8");
        run_op(1'b0, 3'd3, '0, "R8");
        run_op(1'b1, 3'd6, 16'hFFFF, "R8");
        run_op(1'b0, 3'd6, '0, "R8");

        // R10: write offered while busy is ignored
        run_op(1'b0, 3'd5, '0, "R8");
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = 3'd5;
        cmd_wdata = 16'hDEAD;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        run_op(1'b0, 3'd5, '0, "R10");

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(cmd_ready && !bus_req, "R2", {cmd_ready, bus_req}, 2'b10);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule